// File: doc/BRIEF.md
# Processor Mode and Status Register Unit

This block keeps the current program status word of a processor core together with one saved status word for each privileged mode. It takes five exception requests (fast interrupt, interrupt, software interrupt, undefined instruction, memory abort), picks one by fixed priority and switches into the matching mode. On entry the status in force is stored in the saved slot of the new mode and interrupt masking is raised.

The core's decode stage uses the block through three operations: a read of the current and saved status words, a write of either word (flags field and control byte written separately for the current word), and a return that restores the saved word of the current mode. Control writes are checked against the set of defined mode codes, and a rejected write leaves the control byte alone and raises a one-cycle error flag. The block only supplies mode and flags; vectoring and register banking live elsewhere.

Top module: `psr_mode_unit`

## Requirements
- R1: After reset `cur_psr` is 0x000000D3 (supervisor mode 10011, bit 7 and bit 6 set, flags clear), `sav_psr` is 0, `is_priv` is 1 and `mode_err` is 0.
- R2: The status word holds flags N,Z,C,V in bits 31..28, the interrupt mask in bit 7, the fast-interrupt mask in bit 6 and the mode in bits 4..0; bits 27..8 and bit 5 always read zero, in `cur_psr` and in `sav_psr`.
- R3: A request enters its mode in the cycle after it is raised: interrupt 10010, fast interrupt 10001, software interrupt 10011, undefined instruction 11011, memory abort 10111.
- R4: When several requests are raised together the winner is, from highest: abort, undefined, fast interrupt, interrupt, software interrupt.
- R5: On entry the previous `cur_psr` is copied into the saved slot of the target mode, flags are kept, bit 7 is set, and bit 6 is set only for a fast interrupt (otherwise it keeps its value).
- R6: A cycle with any request ignores return and all writes raised in that cycle, and `mode_err` stays 0.
- R7: `cur_wr_flags` writes bits 31..28 of `cur_wr_data` into the flags in any mode, including when the control part of the same write is rejected.
- R8: `cur_wr_ctrl` from a user mode (00000 or 10000) changes nothing in bits 7..0 and does not raise `mode_err`.
- R9: Defined modes are 00000-00011, 10000-10011, 10111 and 11011; a privileged control write with a defined mode replaces bits 7, 6 and 4..0, while any other code (including 00111 and 01011) leaves bits 7..0 unchanged and holds `mode_err` high for exactly the next cycle.
- R10: `sav_psr` shows the saved slot of the current mode and 0 in a user mode; `sav_wr_en` in a privileged mode replaces that slot when `sav_wr_data[4:0]` is defined, is rejected with `mode_err` otherwise, and is ignored in a user mode.
- R11: `ret_en` in a privileged mode loads the saved slot of the current mode into `cur_psr` in one cycle; in a user mode it does nothing. A return takes precedence over writes raised in the same cycle.
- R12: The 26-bit privileged modes 00001, 00010, 00011 share the saved slot of 10001, 10010, 10011 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Interrupt request |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined instruction request |
| req_abt | input | 1 | Memory abort request |
| cur_wr_flags | input | 1 | Write flags field of current word |
| cur_wr_ctrl | input | 1 | Write control byte of current word |
| cur_wr_data | input | 32 | Data for current word write |
| sav_wr_en | input | 1 | Write saved word of current mode |
| sav_wr_data | input | 32 | Data for saved word write |
| ret_en | input | 1 | Restore saved word of current mode |
| cur_psr | output | 32 | Current status word |
| sav_psr | output | 32 | Saved status word of current mode |
| cur_mode | output | 5 | Current mode code |
| is_priv | output | 1 | Current mode is privileged |
| mode_err | output | 1 | Previous cycle rejected a mode code |

## Verification
A wrong entry in a saved slot stays hidden until the core either enters that mode again or issues a return, so sweeps interleave entries, slot writes and returns across all modes and compare `sav_psr` on every cycle. A wrong mode or mask bit in the current word shows on `cur_psr` the cycle after the operation that produced it, and a bad validity decision shows on `mode_err` in that same cycle. Every request combination and every five-bit mode code are driven directly, so priority and code-acceptance faults surface within a single operation.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W       = 32;
  localparam int MODE_W      = 5;
  localparam int NUM_SAVED   = 5;
  localparam int SLOT_W      = $clog2(NUM_SAVED);
  localparam int NUM_REQ     = 5;
  localparam int REQ_SEL_W   = $clog2(NUM_REQ);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  // request slots, slot 0 wins
  localparam logic [REQ_SEL_W-1:0] SLOT_ABT = 3'd0;
  localparam logic [REQ_SEL_W-1:0] SLOT_UND = 3'd1;
  localparam logic [REQ_SEL_W-1:0] SLOT_FIQ = 3'd2;
  localparam logic [REQ_SEL_W-1:0] SLOT_IRQ = 3'd3;

  typedef struct packed {
    logic [3:0]        nzcv;
    logic              irq_off;
    logic              fiq_off;
    logic [MODE_W-1:0] mode;
  } psr_t;

  localparam int PSR_BITS = $bits(psr_t);

  typedef struct packed {
    logic              legal;
    logic              priv;
    logic [SLOT_W-1:0] slot;
  } mode_info_t;

  function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] m);
    mode_info_t r;
    r = '0;
    case (m)
      5'b00000, MODE_USR: r.legal = 1'b1;
      5'b00001, MODE_FIQ: begin r.legal = 1'b1; r.priv = 1'b1; r.slot = SLOT_W'(0); end
      5'b00010, MODE_IRQ: begin r.legal = 1'b1; r.priv = 1'b1; r.slot = SLOT_W'(1); end
      5'b00011, MODE_SVC: begin r.legal = 1'b1; r.priv = 1'b1; r.slot = SLOT_W'(2); end
      MODE_ABT:           begin r.legal = 1'b1; r.priv = 1'b1; r.slot = SLOT_W'(3); end
      MODE_UND:           begin r.legal = 1'b1; r.priv = 1'b1; r.slot = SLOT_W'(4); end
      default:            r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [MODE_W-1:0] req_target(input logic [REQ_SEL_W-1:0] s);
    case (s)
      SLOT_ABT: return MODE_ABT;
      SLOT_UND: return MODE_UND;
      SLOT_FIQ: return MODE_FIQ;
      SLOT_IRQ: return MODE_IRQ;
      default:  return MODE_SVC;
    endcase
  endfunction

  function automatic logic [PSR_W-1:0] psr_word(input psr_t p);
    return {p.nzcv, 20'd0, p.irq_off, p.fiq_off, 1'b0, p.mode};
  endfunction

  function automatic psr_t psr_unpack(input logic [PSR_W-1:0] w);
    psr_t p;
    p.nzcv    = w[31:28];
    p.irq_off = w[7];
    p.fiq_off = w[6];
    p.mode    = w[4:0];
    return p;
  endfunction
endpackage

// File: rtl/psr_exc_arbiter.sv
module psr_exc_arbiter
  import psr_pkg::*;
#(
  parameter int N_REQ = NUM_REQ
) (
  input  logic [N_REQ-1:0]  req,
  output logic              take,
  output logic [MODE_W-1:0] tgt_mode,
  output logic              tgt_masks_fiq
);
  localparam int SEL_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [SEL_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (req[k]) sel = SEL_W'(k);
    end
  end

  assign take          = |req;
  assign tgt_mode      = req_target(REQ_SEL_W'(sel));
  assign tgt_masks_fiq = (REQ_SEL_W'(sel) == SLOT_FIQ);
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank #(
  parameter int DEPTH  = 5,
  parameter int WIDTH  = 11,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] filled;

  // storage carries no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) filled <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  assign rdata = filled[raddr] ? mem[raddr] : '0;
endmodule

// File: rtl/psr_mode_unit.sv
module psr_mode_unit
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_fiq,
  input  logic             req_irq,
  input  logic             req_swi,
  input  logic             req_und,
  input  logic             req_abt,
  input  logic             cur_wr_flags,
  input  logic             cur_wr_ctrl,
  input  logic [31:0]      cur_wr_data,
  input  logic             sav_wr_en,
  input  logic [31:0]      sav_wr_data,
  input  logic             ret_en,
  output logic [31:0]      cur_psr,
  output logic [31:0]      sav_psr,
  output logic [4:0]       cur_mode,
  output logic             is_priv,
  output logic             mode_err
);
  localparam psr_t RESET_PSR = '{nzcv: 4'd0, irq_off: 1'b1, fiq_off: 1'b1, mode: MODE_SVC};

  psr_t       cur_q, cur_d;
  logic       err_q, err_d;
  mode_info_t cur_info, wr_info, sav_info, tgt_info;
  psr_t       wr_p, sav_p, bank_rd, bank_wd;
  logic       bank_we;
  logic [SLOT_W-1:0] bank_wa;

  logic              exc_take;
  logic [MODE_W-1:0] exc_mode;
  logic              exc_fiq;

  psr_exc_arbiter #(.N_REQ(NUM_REQ)) u_arb (
    .req           ({req_swi, req_irq, req_fiq, req_und, req_abt}),
    .take          (exc_take),
    .tgt_mode      (exc_mode),
    .tgt_masks_fiq (exc_fiq)
  );

  psr_saved_bank #(.DEPTH(NUM_SAVED), .WIDTH(PSR_BITS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (bank_we),
    .waddr (bank_wa),
    .wdata (bank_wd),
    .raddr (cur_info.slot),
    .rdata (bank_rd)
  );

  always_comb begin
    wr_p     = psr_unpack(cur_wr_data);
    sav_p    = psr_unpack(sav_wr_data);
    cur_info = decode_mode(cur_q.mode);
    wr_info  = decode_mode(wr_p.mode);
    sav_info = decode_mode(sav_p.mode);
    tgt_info = decode_mode(exc_mode);
  end

  always_comb begin
    cur_d   = cur_q;
    err_d   = 1'b0;
    bank_we = 1'b0;
    bank_wa = cur_info.slot;
    bank_wd = sav_p;
    if (exc_take) begin
      bank_we       = 1'b1;
      bank_wa       = tgt_info.slot;
      bank_wd       = cur_q;
      cur_d.mode    = exc_mode;
      cur_d.irq_off = 1'b1;
      if (exc_fiq) cur_d.fiq_off = 1'b1;
    end else if (ret_en) begin
      if (cur_info.priv) cur_d = bank_rd;
    end else begin
      if (cur_wr_flags) cur_d.nzcv = wr_p.nzcv;
      if (cur_wr_ctrl && cur_info.priv) begin
        if (wr_info.legal) begin
          cur_d.irq_off = wr_p.irq_off;
          cur_d.fiq_off = wr_p.fiq_off;
          cur_d.mode    = wr_p.mode;
        end else begin
          err_d = 1'b1;
        end
      end
      if (sav_wr_en && cur_info.priv) begin
        if (sav_info.legal) bank_we = 1'b1;
        else                err_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= RESET_PSR;
      err_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      err_q <= err_d;
    end
  end

  assign cur_psr  = psr_word(cur_q);
  assign sav_psr  = cur_info.priv ? psr_word(bank_rd) : '0;
  assign cur_mode = cur_q.mode;
  assign is_priv  = cur_info.priv;
  assign mode_err = err_q;
endmodule

// File: rtl/psr_mode_unit_chk.sv
module psr_mode_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_fiq,
  input logic        req_irq,
  input logic        req_swi,
  input logic        req_und,
  input logic        req_abt,
  input logic        cur_wr_ctrl,
  input logic        ret_en,
  input logic [31:0] cur_psr,
  input logic [31:0] sav_psr,
  input logic [4:0]  cur_mode,
  input logic        is_priv,
  input logic        mode_err
);
  logic any_req;
  logic mode_ok;
  assign any_req = req_fiq | req_irq | req_swi | req_und | req_abt;
  assign mode_ok = (cur_mode[4:2] == 3'b000) || (cur_mode[4:2] == 3'b100) ||
                   (cur_mode == 5'b10111) || (cur_mode == 5'b11011);

  assert_entry_masks_irq_R5: assert property (@(posedge clk) disable iff (rst)
    any_req |=> cur_psr[7]);

  assert_entry_saves_R5: assert property (@(posedge clk) disable iff (rst)
    any_req |=> sav_psr == $past(cur_psr));

  assert_fiq_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (req_fiq && !req_abt && !req_und) |=> (cur_mode == 5'b10001) && cur_psr[6]);

  assert_abort_wins_R4: assert property (@(posedge clk) disable iff (rst)
    req_abt |=> cur_mode == 5'b10111);

  assert_entry_no_err_R6: assert property (@(posedge clk) disable iff (rst)
    any_req |=> !mode_err);

  assert_user_ctrl_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!any_req && !ret_en && cur_wr_ctrl && !is_priv) |=>
      (cur_psr[7:0] == $past(cur_psr[7:0])) && !mode_err);

  assert_return_restores_R11: assert property (@(posedge clk) disable iff (rst)
    (!any_req && ret_en && is_priv) |=> cur_psr == $past(sav_psr));

  assert_mode_defined_R9: assert property (@(posedge clk) disable iff (rst)
    mode_ok);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_psr[27:8] == 20'd0) && !cur_psr[5] && (sav_psr[27:8] == 20'd0) && !sav_psr[5]);
endmodule

bind psr_mode_unit psr_mode_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_fiq     (req_fiq),
  .req_irq     (req_irq),
  .req_swi     (req_swi),
  .req_und     (req_und),
  .req_abt     (req_abt),
  .cur_wr_ctrl (cur_wr_ctrl),
  .ret_en      (ret_en),
  .cur_psr     (cur_psr),
  .sav_psr     (sav_psr),
  .cur_mode    (cur_mode),
  .is_priv     (is_priv),
  .mode_err    (mode_err)
);

// File: tb/sim_psr_mode_unit.sv
module sim_psr_mode_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_fiq = 0, req_irq = 0, req_swi = 0, req_und = 0, req_abt = 0;
  logic cur_wr_flags = 0, cur_wr_ctrl = 0, sav_wr_en = 0, ret_en = 0;
  logic [31:0] cur_wr_data = '0, sav_wr_data = '0;
  logic [31:0] cur_psr, sav_psr;
  logic [4:0]  cur_mode;
  logic        is_priv, mode_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_cur;
  logic [31:0] m_bank [5];
  logic        m_err;

  always #5 clk = ~clk;

  psr_mode_unit u0 (
    .clk(clk), .rst(rst),
    .req_fiq(req_fiq), .req_irq(req_irq), .req_swi(req_swi), .req_und(req_und), .req_abt(req_abt),
    .cur_wr_flags(cur_wr_flags), .cur_wr_ctrl(cur_wr_ctrl), .cur_wr_data(cur_wr_data),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .ret_en(ret_en),
    .cur_psr(cur_psr), .sav_psr(sav_psr), .cur_mode(cur_mode), .is_priv(is_priv), .mode_err(mode_err)
  );

  function automatic bit m_legal(input logic [4:0] m);
    return (m <= 5'd3) || (m >= 5'd16 && m <= 5'd19) || m == 5'd23 || m == 5'd27;
  endfunction
  function automatic bit m_priv(input logic [4:0] m);
    return m_legal(m) && (m[3:0] != 4'd0);
  endfunction
  function automatic int m_slot(input logic [4:0] m);
    case (m[3:0])
      4'd1: return 0;
      4'd2: return 1;
      4'd3: return 2;
      4'd7: return 3;
      default: return 4;
    endcase
  endfunction
  function automatic logic [31:0] clean(input logic [31:0] w);
    return {w[31:28], 20'd0, w[7:6], 1'b0, w[4:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string tcur, input string tsav, input string terr);
    logic [31:0] es;
    es = m_priv(m_cur[4:0]) ? m_bank[m_slot(m_cur[4:0])] : 32'd0;
    check(tcur, cur_psr, m_cur);
    check(tcur, {27'd0, cur_mode}, {27'd0, m_cur[4:0]});
    check(tcur, {31'd0, is_priv}, {31'd0, m_priv(m_cur[4:0])});
    check(tsav, sav_psr, es);
    check(terr, {31'd0, mode_err}, {31'd0, m_err});
  endtask

  task automatic model_step();
    logic [4:0] cm, tg;
    bit e;
    cm = m_cur[4:0];
    e = 0;
    if (req_abt | req_und | req_fiq | req_irq | req_swi) begin
      if (req_abt)      tg = 5'b10111;
      else if (req_und) tg = 5'b11011;
      else if (req_fiq) tg = 5'b10001;
      else if (req_irq) tg = 5'b10010;
      else              tg = 5'b10011;
      m_bank[m_slot(tg)] = m_cur;
      m_cur[4:0] = tg;
      m_cur[7] = 1'b1;
      if (tg == 5'b10001) m_cur[6] = 1'b1;
    end else if (ret_en) begin
      if (m_priv(cm)) m_cur = m_bank[m_slot(cm)];
    end else begin
      if (cur_wr_flags) m_cur[31:28] = cur_wr_data[31:28];
      if (cur_wr_ctrl && m_priv(cm)) begin
        if (m_legal(cur_wr_data[4:0])) m_cur[7:0] = {cur_wr_data[7:6], 1'b0, cur_wr_data[4:0]};
        else e = 1;
      end
      if (sav_wr_en && m_priv(cm)) begin
        if (m_legal(sav_wr_data[4:0])) m_bank[m_slot(cm)] = clean(sav_wr_data);
        else e = 1;
      end
    end
    m_err = e;
  endtask

  task automatic idle_inputs();
    {req_fiq, req_irq, req_swi, req_und, req_abt} = '0;
    {cur_wr_flags, cur_wr_ctrl, sav_wr_en, ret_en} = '0;
    cur_wr_data = '0;
    sav_wr_data = '0;
  endtask

  task automatic step(input string tcur, input string tsav, input string terr);
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    compare_all(tcur, tsav, terr);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cur = 32'h0000_00D3;
    m_err = 1'b0;
    for (int i = 0; i < 5; i++) m_bank[i] = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1", cur_psr, 32'h0000_00D3);
    check("R1", sav_psr, 32'd0);
    check("R1", {31'd0, is_priv}, 32'd1);
    check("R1", {31'd0, mode_err}, 32'd0);

    // R3: each single request
    for (int r = 0; r < 5; r++) begin
      logic [4:0] want;
      do_reset();
      case (r)
        0: begin req_irq = 1; want = 5'b10010; end
        1: begin req_fiq = 1; want = 5'b10001; end
        2: begin req_swi = 1; want = 5'b10011; end
        3: begin req_und = 1; want = 5'b11011; end
        default: begin req_abt = 1; want = 5'b10111; end
      endcase
      step("R3", "R5", "R6");
      check("R3", {27'd0, cur_mode}, {27'd0, want});
    end

    // R4 and R5: every request combination, from a user mode with flags set and masks clear
    for (int c = 1; c < 32; c++) begin
      do_reset();
      cur_wr_flags = 1; cur_wr_ctrl = 1; cur_wr_data = 32'h9000_0010;
      step("R7", "R10", "R9");
      {req_swi, req_irq, req_fiq, req_und, req_abt} = 5'(c);
      step("R4", "R5", "R6");
      check("R5", {31'd0, cur_psr[6]}, {31'd0, (c[2] && !c[1] && !c[0])});
    end

    // R9: sweep every mode code from supervisor mode, flags written alongside (R7)
    for (int m = 0; m < 32; m++) begin
      do_reset();
      cur_wr_flags = 1; cur_wr_ctrl = 1; cur_wr_data = {4'h6, 20'hFFFFF, 3'b011, 5'(m)};
      step("R7", "R10", "R9");
      check("R9", {31'd0, mode_err}, {31'd0, !m_legal(5'(m))});
      check("R2", cur_psr[27:8], 20'd0);
      step("R9", "R10", "R9");
    end

    // R12: 26-bit supervisor shares the 32-bit supervisor slot
    do_reset();
    cur_wr_ctrl = 1; cur_wr_data = 32'h0000_0003;
    step("R12", "R12", "R9");
    sav_wr_en = 1; sav_wr_data = 32'hA123_45D2;
    step("R12", "R12", "R10");
    cur_wr_ctrl = 1; cur_wr_data = 32'h0000_0013;
    step("R12", "R12", "R9");
    check("R12", sav_psr, 32'hA000_00D2);
    ret_en = 1;
    step("R11", "R11", "R11");
    check("R11", cur_psr, 32'hA000_00D2);

    // R8 and R10: user-mode control and saved writes ignored
    do_reset();
    cur_wr_ctrl = 1; cur_wr_data = 32'h0000_0010;
    step("R9", "R10", "R9");
    cur_wr_ctrl = 1; cur_wr_flags = 1; cur_wr_data = 32'h5000_00D3;
    sav_wr_en = 1; sav_wr_data = 32'h0000_0007;
    step("R8", "R10", "R8");
    check("R8", cur_psr, 32'h5000_0010);
    ret_en = 1;
    step("R11", "R10", "R11");
    check("R11", cur_psr, 32'h5000_0010);

    // R6: request overrides return and writes in the same cycle
    do_reset();
    req_irq = 1; ret_en = 1; cur_wr_flags = 1; cur_wr_ctrl = 1;
    cur_wr_data = 32'hF000_0007; sav_wr_en = 1; sav_wr_data = 32'h0000_0007;
    step("R6", "R6", "R6");
    check("R6", cur_psr, 32'h0000_00D2);
    check("R6", sav_psr, 32'h0000_00D3);

    // mixed sweep with all operations interleaved
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[2:0] == 3'd0) {req_swi, req_irq, req_fiq, req_und, req_abt} = rv[7:3];
      ret_en       = (rv[10:8] == 3'd0);
      cur_wr_flags = rv[11];
      cur_wr_ctrl  = rv[12];
      sav_wr_en    = rv[13];
      cur_wr_data  = $urandom;
      sav_wr_data  = $urandom;
      if (rv[14]) cur_wr_data[4:0] = rv[15] ? 5'b10011 : {1'b0, 2'b00, rv[17:16]};
      if (rv[18]) sav_wr_data[4:0] = {rv[19], 2'b00, rv[21:20]};
      step("R11", "R10", "R9");
    end

    finish_run();
  end
endmodule